// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block sits beside the serial command decoder of a small-sector serial flash. It owns the 8-bit status register, the write-enable latch and the busy flag. It turns decoded command pulses into status updates and into self-timed program, status-write and erase cycles. A five-bit protect code marks an upper part of the array as read-only. An active-low write-protect pin, combined with the protect-enable bit, can freeze the status register itself.

The decoder raises one-cycle pulses. Four of them mark commands: write-enable, write-disable, the end of a status data byte and a program or erase request. A fifth marks the rising edge of chip select. A combinational lookup tells the decoder whether any address is locked. Erase cycles finish with a sweep that emits one wipe pulse per 4 KiB sector to be cleared. The sweep skips every sector the protect code covers.

Top module: `status_protect_ctrl`

## Requirements
- R1: After reset `status_rd` reads 00h. The layout is bit 7 protect-enable, bits 6..2 protect code P4..P0, bit 1 write-enable latch and bit 0 busy.
- R2: A write-enable pulse sets bit 1 and a write-disable pulse clears it, whatever the level of `wp_n`.
- R3: A status write is armed by `wrsr_load` only if bit 1 is set. It starts at the next `cs_rise` and keeps busy high for SR_CYCLES cycles. At the end, bits 7..2 take bits 7..2 of the loaded byte, bits 1..0 of that byte are dropped, and bit 1 is cleared.
- R4: While busy, `status_rd` reads FFh.
- R5: `chk_locked` follows the protect code P4..P0 (x = don't care). 00000 locks nothing; 01000 locks 07E000h up; 10000 locks 07C000h up; 11000 locks 078000h up; xx001 locks 070000h up; xx010 locks 060000h up; xx011 locks 040000h up; xx1xx locks the whole array.
- R6: When `wp_n` is low and bit 7 is 1, a status write is refused and busy stays low. Programs to unlocked addresses are still accepted.
- R7: `wp_n` going low with bit 7 set, after `wrsr_load` and no later than `cs_rise`, cancels the status write. Once the cycle has started, `wp_n` has no effect on it.
- R8: A program request needs bit 1 set and an unlocked `op_addr`. It keeps busy for PROG_CYCLES cycles and clears bit 1 at the end.
- R9: An erase with bit 1 clear, or whose target is locked, is rejected and busy stays low. The target is `op_addr` for a sector, the 64 KiB block base for a block, and address 0 for the chip. `erase_kind` is 0 for sector, 1 for block and 2 for chip.
- R10: A sector erase is busy for SECT_CYCLES cycles, then emits one wipe of sector `op_addr[18:12]` in one further busy cycle.
- R11: A block erase is busy for BLK_CYCLES cycles, then spends 16 sweep cycles on the block's sectors in ascending order. It wipes only the unlocked ones.
- R12: A chip erase is busy for CHIP_CYCLES cycles, then spends 128 sweep cycles on sectors 0..127. It wipes only the unlocked ones. Bit 1 clears at the end of every erase.
- R13: While busy, every command pulse other than a status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wp_n | input | 1 | write-protect pin, active low |
| wren_cmd | input | 1 | write-enable command pulse |
| wrdi_cmd | input | 1 | write-disable command pulse |
| wrsr_load | input | 1 | status data byte complete |
| wrsr_byte | input | 8 | status data byte |
| cs_rise | input | 1 | chip select rising edge pulse |
| prog_req | input | 1 | program cycle request |
| erase_req | input | 1 | erase cycle request |
| erase_kind | input | 2 | 0 sector, 1 block, 2 chip |
| op_addr | input | ADDR_W | program or erase address |
| chk_addr | input | ADDR_W | address to test for lock-out |
| status_rd | output | 8 | status read value |
| chk_locked | output | 1 | `chk_addr` is locked |
| wipe_valid | output | 1 | clear the sector in `wipe_sector` |
| wipe_sector | output | ADDR_W-12 | sector index to clear |

## Verification
The assertions assume the decoder raises at most one command pulse per cycle. They also assume every cycle-length parameter is at least 1. The bench drives one pulse at a time on the falling clock edge. Its only deliberate overlap is a write-enable issued together with an erase request inside a running cycle, where both must be ignored. `wp_n` changes only between pulses or in the same cycle as `cs_rise`, which is the window the cancel rule defines.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_SWEEP} phase_e;
    typedef enum logic [2:0] {OP_SR, OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_e;

    localparam logic [1:0] KIND_SECT = 2'd0;
    localparam logic [1:0] KIND_BLK  = 2'd1;
    localparam logic [1:0] KIND_CHIP = 2'd2;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // number of top address bits that must be ones for a location to be locked
    function automatic logic [2:0] lock_depth(logic [4:0] code);
        logic [2:0] k;
        case (code[1:0])
            2'd1:    k = 3'd3;
            2'd2:    k = 3'd2;
            2'd3:    k = 3'd1;
            default: begin
                case (code[4:3])
                    2'd1:    k = 3'd6;
                    2'd2:    k = 3'd5;
                    2'd3:    k = 3'd4;
                    default: k = 3'd0;
                endcase
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/prot_map.sv
module prot_map #(
    parameter int ADDR_W = 19
) (
    input  logic [4:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import spc_pkg::*;

    logic [2:0]        depth;
    logic [ADDR_W-1:0] mask;

    always_comb begin
        depth  = lock_depth(code);
        mask   = ~({ADDR_W{1'b1}} >> depth);
        locked = code[2] | ((depth != 3'd0) && ((addr & mask) == mask));
    end

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load)
            tmr_d.cnt = load_val;
        else if (tmr_q.cnt != '0)
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        expire = (tmr_q.cnt == TW'(1)) && !load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.cnt != '0 && !load) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));

    assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/status_protect_ctrl.sv
module status_protect_ctrl #(
    parameter int ADDR_W      = 19,
    parameter int SECT_W      = 12,
    parameter int BLK_W       = 16,
    parameter int SR_CYCLES   = 64,
    parameter int PROG_CYCLES = 32,
    parameter int SECT_CYCLES = 200,
    parameter int BLK_CYCLES  = 500,
    parameter int CHIP_CYCLES = 1600
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wp_n,
    input  logic                     wren_cmd,
    input  logic                     wrdi_cmd,
    input  logic                     wrsr_load,
    input  logic [7:0]               wrsr_byte,
    input  logic                     cs_rise,
    input  logic                     prog_req,
    input  logic                     erase_req,
    input  logic [1:0]               erase_kind,
    input  logic [ADDR_W-1:0]        op_addr,
    input  logic [ADDR_W-1:0]        chk_addr,
    output logic [7:0]               status_rd,
    output logic                     chk_locked,
    output logic                     wipe_valid,
    output logic [ADDR_W-SECT_W-1:0] wipe_sector
);
    import spc_pkg::*;

    localparam int SIDX_W = ADDR_W - SECT_W;
    localparam int SPB_W  = BLK_W - SECT_W;
    localparam int MAXC   = max2(max2(SR_CYCLES, PROG_CYCLES),
                                 max2(max2(SECT_CYCLES, BLK_CYCLES), CHIP_CYCLES));
    localparam int TW     = $clog2(MAXC + 1);
    localparam int NLOOK  = 3;

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic              wpen;
        logic [4:0]        code;
        logic              wen;
        logic [5:0]        stage;
        logic              pend;
        logic [SIDX_W-1:0] cur;
        logic [SIDX_W-1:0] last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              busy, hw_lock, t_load, t_expire;
    logic [TW-1:0]     t_val;
    logic [ADDR_W-1:0] tgt_addr;
    logic [ADDR_W-1:0] look_addr [NLOOK];
    logic              look_lock [NLOOK];

    // lookups: 0 = request target, 1 = external query, 2 = sweep position
    assign look_addr[0] = tgt_addr;
    assign look_addr[1] = chk_addr;
    assign look_addr[2] = {ctl_q.cur, {SECT_W{1'b0}}};

    for (genvar g = 0; g < NLOOK; g++) begin : g_look
        prot_map #(.ADDR_W(ADDR_W)) u_map (
            .code   (ctl_q.code),
            .addr   (look_addr[g]),
            .locked (look_lock[g])
        );
    end

    cycle_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expire   (t_expire)
    );

    always_comb begin
        if (!erase_req)                  tgt_addr = op_addr;
        else if (erase_kind == KIND_BLK) tgt_addr = {op_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
        else if (erase_kind == KIND_CHIP) tgt_addr = '0;
        else                             tgt_addr = op_addr;
    end

    always_comb begin
        ctl_d      = ctl_q;
        t_load     = 1'b0;
        t_val      = '0;
        wipe_valid = 1'b0;
        busy       = (ctl_q.phase != PH_IDLE);
        hw_lock    = !wp_n && ctl_q.wpen;

        case (ctl_q.phase)
            PH_IDLE: begin
                if (wrdi_cmd)      ctl_d.wen = 1'b0;
                else if (wren_cmd) ctl_d.wen = 1'b1;

                if (wrsr_load) begin
                    ctl_d.pend  = ctl_q.wen && !hw_lock;
                    ctl_d.stage = wrsr_byte[7:2];
                end else if (hw_lock) begin
                    ctl_d.pend  = 1'b0;
                end

                if (cs_rise) begin
                    ctl_d.pend = 1'b0;
                    if (ctl_q.pend && !hw_lock) begin
                        ctl_d.phase = PH_WAIT;
                        ctl_d.op    = OP_SR;
                        t_load      = 1'b1;
                        t_val       = TW'(SR_CYCLES);
                    end
                end else if (prog_req && ctl_q.wen && !look_lock[0]) begin
                    ctl_d.phase = PH_WAIT;
                    ctl_d.op    = OP_PROG;
                    t_load      = 1'b1;
                    t_val       = TW'(PROG_CYCLES);
                end else if (erase_req && ctl_q.wen && !look_lock[0]) begin
                    ctl_d.phase = PH_WAIT;
                    t_load      = 1'b1;
                    if (erase_kind == KIND_BLK) begin
                        ctl_d.op   = OP_BLK;
                        t_val      = TW'(BLK_CYCLES);
                        ctl_d.cur  = {op_addr[ADDR_W-1:BLK_W], {SPB_W{1'b0}}};
                        ctl_d.last = {op_addr[ADDR_W-1:BLK_W], {SPB_W{1'b1}}};
                    end else if (erase_kind == KIND_CHIP) begin
                        ctl_d.op   = OP_CHIP;
                        t_val      = TW'(CHIP_CYCLES);
                        ctl_d.cur  = '0;
                        ctl_d.last = '1;
                    end else begin
                        ctl_d.op   = OP_SECT;
                        t_val      = TW'(SECT_CYCLES);
                        ctl_d.cur  = op_addr[ADDR_W-1:SECT_W];
                        ctl_d.last = op_addr[ADDR_W-1:SECT_W];
                    end
                end
            end
            PH_WAIT: begin
                if (t_expire) begin
                    if (ctl_q.op == OP_SR) begin
                        ctl_d.wpen  = ctl_q.stage[5];
                        ctl_d.code  = ctl_q.stage[4:0];
                        ctl_d.wen   = 1'b0;
                        ctl_d.phase = PH_IDLE;
                    end else if (ctl_q.op == OP_PROG) begin
                        ctl_d.wen   = 1'b0;
                        ctl_d.phase = PH_IDLE;
                    end else begin
                        ctl_d.phase = PH_SWEEP;
                    end
                end
            end
            default: begin
                wipe_valid = !look_lock[2];
                if (ctl_q.cur == ctl_q.last) begin
                    ctl_d.wen   = 1'b0;
                    ctl_d.phase = PH_IDLE;
                end else begin
                    ctl_d.cur = ctl_q.cur + 1'b1;
                end
            end
        endcase

        status_rd   = busy ? 8'hFF : {ctl_q.wpen, ctl_q.code, ctl_q.wen, 1'b0};
        chk_locked  = look_lock[1];
        wipe_sector = ctl_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
            ctl_q.op    <= OP_SR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assert_prot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_IDLE) |=> $stable({ctl_q.wpen, ctl_q.code}));

    assert_wen_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !ctl_q.wen);

    assert_reject_no_wen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctl_q.wen) |=> !busy);

    assert_hw_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cs_rise && !wp_n && ctl_q.wpen) |=> !busy);

    assert_sweep_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_SWEEP) |-> (ctl_q.cur <= ctl_q.last));

endmodule

// File: tb/status_protect_ctrl_test.sv
module status_protect_ctrl_test;

    localparam int AW = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic wren_cmd = 1'b0, wrdi_cmd = 1'b0, wrsr_load = 1'b0, cs_rise = 1'b0;
    logic prog_req = 1'b0, erase_req = 1'b0;
    logic [7:0] wrsr_byte = '0;
    logic [1:0] erase_kind = '0;
    logic [AW-1:0] op_addr = '0, chk_addr = '0;
    logic [7:0] status_rd;
    logic chk_locked, wipe_valid;
    logic [6:0] wipe_sector;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    status_protect_ctrl #(
        .SR_CYCLES(4), .PROG_CYCLES(3), .SECT_CYCLES(5), .BLK_CYCLES(6), .CHIP_CYCLES(7)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .wren_cmd(wren_cmd), .wrdi_cmd(wrdi_cmd), .wrsr_load(wrsr_load),
        .wrsr_byte(wrsr_byte), .cs_rise(cs_rise), .prog_req(prog_req),
        .erase_req(erase_req), .erase_kind(erase_kind), .op_addr(op_addr),
        .chk_addr(chk_addr), .status_rd(status_rd), .chk_locked(chk_locked),
        .wipe_valid(wipe_valid), .wipe_sector(wipe_sector)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_lock(input logic [4:0] code, input int addr);
        int frac;
        if (code[2]) return 1'b1;
        case (code[1:0])
            2'd1: frac = 8;
            2'd2: frac = 4;
            2'd3: frac = 2;
            default: case (code[4:3])
                2'd1: frac = 64;
                2'd2: frac = 32;
                2'd3: frac = 16;
                default: return 1'b0;
            endcase
        endcase
        return addr >= (524288 - 524288 / frac);
    endfunction

    task automatic do_wren;
        wren_cmd = 1'b1; @(negedge clk); wren_cmd = 1'b0;
    endtask

    task automatic do_wrdi;
        wrdi_cmd = 1'b1; @(negedge clk); wrdi_cmd = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] b);
        wrsr_load = 1'b1; wrsr_byte = b; @(negedge clk); wrsr_load = 1'b0;
    endtask

    task automatic do_cs;
        cs_rise = 1'b1; @(negedge clk); cs_rise = 1'b0;
    endtask

    task automatic do_erase(input logic [1:0] kind, input int addr);
        erase_req = 1'b1; erase_kind = kind; op_addr = AW'(addr);
        @(negedge clk); erase_req = 1'b0;
    endtask

    task automatic do_prog(input int addr);
        prog_req = 1'b1; op_addr = AW'(addr); @(negedge clk); prog_req = 1'b0;
    endtask

    task automatic wait_idle(input bit inject, output int cyc, output int nw,
                             output int lo, output int hi);
        cyc = 0; nw = 0; lo = -1; hi = -1;
        while (status_rd[0] && cyc < 2000) begin
            if (wipe_valid) begin
                if (lo < 0) lo = int'(wipe_sector);
                hi = int'(wipe_sector);
                nw++;
            end
            if (inject && cyc == 2) begin
                wren_cmd = 1'b1; erase_req = 1'b1; erase_kind = 2'd0; op_addr = '0;
            end else begin
                wren_cmd = 1'b0; erase_req = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        wren_cmd = 1'b0; erase_req = 1'b0;
    endtask

    task automatic set_status(input logic [7:0] b);
        int c, w, l, h;
        do_wren; do_load(b); do_cs;
        wait_idle(1'b0, c, w, l, h);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int c, w, l, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(status_rd == 8'h00, "R1 reset value", status_rd, 8'h00);

        // status write without write-enable is not armed
        do_load(8'h9C); do_cs;
        check(status_rd == 8'h00, "R3 write without enable", status_rd, 8'h00);

        do_wren;
        check(status_rd == 8'h02, "R2 enable sets bit1", status_rd, 8'h02);
        do_wrdi;
        check(status_rd == 8'h00, "R2 disable clears bit1", status_rd, 8'h00);

        // full status write, bits 1..0 of the byte dropped
        do_wren; do_load(8'h7F); do_cs;
        check(status_rd == 8'hFF, "R4 busy reads FF", status_rd, 8'hFF);
        wait_idle(1'b0, c, w, l, h);
        check(c == 4, "R3 status cycle length", c, 4);
        check(status_rd == 8'h7C, "R3 written bits and enable cleared", status_rd, 8'h7C);

        // sweep of all protect codes against the address map
        for (int code = 0; code < 32; code++) begin
            set_status(8'(code << 2));
            check(status_rd == 8'(code << 2), "R3 code readback", status_rd, code << 2);
            for (int s = 0; s < 128; s++) begin
                for (int e = 0; e < 2; e++) begin
                    int a;
                    a = s * 4096 + e * 4095;
                    chk_addr = AW'(a);
                    #1;
                    check(chk_locked == exp_lock(5'(code), a), "R5 lock map",
                          chk_locked, exp_lock(5'(code), a));
                end
            end
        end

        // hardware protection
        set_status(8'h80);
        wp_n = 1'b0;
        do_wren;
        do_wrdi;
        check(status_rd == 8'h80, "R2 disable ignores WP", status_rd, 8'h80);
        do_wren; do_load(8'h84); do_cs;
        check(status_rd == 8'h82, "R6 status write refused", status_rd, 8'h82);
        do_prog(0);
        wait_idle(1'b0, c, w, l, h);
        check(c == 3, "R6 R8 program length under WP", c, 3);
        check(status_rd == 8'h80, "R8 enable cleared after program", status_rd, 8'h80);
        wp_n = 1'b1;

        // WP falling before chip select rises cancels
        do_wren; do_load(8'h88);
        wp_n = 1'b0; do_cs;
        check(status_rd == 8'h82, "R7 cancel before start", status_rd, 8'h82);
        wp_n = 1'b1;
        // WP falling after start has no effect
        do_load(8'h84); do_cs;
        wp_n = 1'b0;
        wait_idle(1'b0, c, w, l, h);
        check(status_rd == 8'h84, "R7 no effect after start", status_rd, 8'h84);
        wp_n = 1'b1;

        // upper 1/64 locked
        set_status(8'h20);
        do_erase(2'd0, 32'h012345);
        check(status_rd == 8'h20, "R9 erase without enable", status_rd, 8'h20);
        do_wren; do_erase(2'd0, 32'h07F000);
        check(status_rd == 8'h22, "R9 locked sector rejected", status_rd, 8'h22);
        do_prog(32'h07E010);
        check(status_rd == 8'h22, "R8 locked program rejected", status_rd, 8'h22);
        do_erase(2'd0, 32'h012345);
        wait_idle(1'b0, c, w, l, h);
        check(c == 6 && w == 1 && l == 18, "R10 sector erase", (c << 16) | (w << 8) | l,
              (6 << 16) | (1 << 8) | 18);
        check(status_rd == 8'h20, "R12 enable cleared after erase", status_rd, 8'h20);
        do_wren; do_erase(2'd1, 32'h075555);
        wait_idle(1'b0, c, w, l, h);
        check(c == 22 && w == 14 && l == 112 && h == 125, "R11 block erase skips locked",
              (c << 24) | (w << 16) | (l << 8) | h, (22 << 24) | (14 << 16) | (112 << 8) | 125);

        // upper half locked
        set_status(8'h0C);
        do_wren; do_erase(2'd1, 32'h040000);
        check(status_rd == 8'h0E, "R9 locked block rejected", status_rd, 8'h0E);
        do_erase(2'd2, 0);
        wait_idle(1'b1, c, w, l, h);
        check(c == 135 && w == 64 && l == 0 && h == 63, "R12 R13 chip erase skips locked",
              (c << 24) | (w << 16) | (l << 8) | h, (135 << 24) | (64 << 16) | 63);
        check(status_rd == 8'h0C, "R13 enable during busy ignored", status_rd, 8'h0C);

        // whole array locked
        set_status(8'h10);
        do_wren; do_erase(2'd2, 0);
        check(status_rd == 8'h12, "R9 chip erase rejected when all locked", status_rd, 8'h12);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule